// File: doc/BRIEF.md
# Two-Digit Multiplexed Hex Display Driver

This block shows an 8-bit switch value as two hexadecimal characters on a seven-segment display with two digits. Both digits share one set of segment lines, and each digit has a common cathode. A single hex-to-segment decoder serves both digits in turn. A free-running prescaler counter divides the system clock. The top bit of that counter picks which nibble reaches the decoder, and the same bit decides which digit-enable line is driven.

The switch inputs are asynchronous, so they pass through a synchronizer before the selector. When the select bit is high, the display shows the upper nibble on the most-significant digit. When it is low, it shows the lower nibble on the least-significant digit. The least-significant enable is always the inverse of the most-significant enable. With a 12 MHz clock, the default 17-bit counter gives a select period of 2^17 clocks. A bench can shrink the counter so that it sees every phase quickly.

Top module: `hex_pair_display`

## Requirements
- R1: While the synchronous active-high reset is asserted, the counter and synchronizer clear. The outputs then show the low-digit phase: `lo_en_o`=1, `hi_en_o`=0 and segments 7'h3F (glyph 0). The first cycle after reset is also a low-digit cycle.
- R2: The counter is CNT_W bits wide and advances by one every clock. The select bit is its top bit, so each digit phase lasts 2^(CNT_W-1) clocks, and the enables change only when the lower CNT_W-1 counter bits are zero.
- R3: While `hi_en_o` is 1, the segments show the glyph of synchronized switch bits 7:4.
- R4: While `lo_en_o` is 1, the segments show the glyph of synchronized switch bits 3:0.
- R5: `lo_en_o` is always the inverse of `hi_en_o`. Exactly one enable is high in every cycle, and both enables are active high.
- R6: Segments are active high, with bit 6 to bit 0 = g,f,e,d,c,b,a. The glyphs for 0 through F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (lowercase b and d).
- R7: A switch change reaches the segments after exactly SYNC_STAGES (default 2) rising edges. While the synchronized value and the phase both hold, the segments hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_i | input | 8 | Switch value, upper nibble for high digit |
| seg_o | output | 7 | Segment lines {g,f,e,d,c,b,a}, active high |
| hi_en_o | output | 1 | Most-significant digit enable, active high |
| lo_en_o | output | 1 | Least-significant digit enable, active high |

## Verification
The assertions check several properties on every cycle. The two enables always differ. A phase change happens only at a counter wrap of the lower bits. The state after reset is the low-digit phase with a cleared counter. Every displayed pattern lights at least two segments. The segments hold whenever the synchronized input and the phase hold. Only the bench scenarios can show that the right nibble appears in the right phase with the exact glyph for all sixteen values. They also show the switch-to-segment latency and the exact phase lengths, which the bench checks against its own cycle model.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;

    typedef logic [NIB_W-1:0] nibble_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Segment order {g,f,e,d,c,b,a}, active high
    function automatic seg_t hex_glyph(input nibble_t v);
        seg_t s;
        unique case (v)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.stage[STAGES-1];

endmodule

// File: rtl/hpd_prescaler.sv
module hpd_prescaler #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count_o,
    output logic             phase_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign phase_o = st_q.cnt[CNT_W-1];

endmodule

// File: rtl/hpd_digit_mux.sv
module hpd_digit_mux
    import hpd_pkg::*;
(
    input  logic [2*NIB_W-1:0] value_i,
    input  logic               phase_i,
    output seg_t               seg_o,
    output logic               hi_en_o,
    output logic               lo_en_o
);

    nibble_t picked;
    phase_e  ph;

    always_comb begin
        ph      = phase_e'(phase_i);
        picked  = (ph == PH_HIGH) ? value_i[2*NIB_W-1:NIB_W] : value_i[NIB_W-1:0];
        seg_o   = hex_glyph(picked);
        hi_en_o = (ph == PH_HIGH);
        lo_en_o = ~hi_en_o;
    end

endmodule

// File: rtl/hex_pair_display.sv
module hex_pair_display
    import hpd_pkg::*;
#(
    parameter int CNT_W       = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] sw_i,
    output logic [6:0] seg_o,
    output logic       hi_en_o,
    output logic       lo_en_o
);

    localparam int SW_W = 2 * NIB_W;

    logic [SW_W-1:0]  sw_sync;
    logic [CNT_W-1:0] sel_cnt;
    logic             sel_phase;

    hpd_sync #(
        .WIDTH (SW_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(sw_i),
        .sync_o (sw_sync)
    );

    hpd_prescaler #(
        .CNT_W(CNT_W)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .count_o(sel_cnt),
        .phase_o(sel_phase)
    );

    hpd_digit_mux u_mux (
        .value_i(sw_sync),
        .phase_i(sel_phase),
        .seg_o  (seg_o),
        .hi_en_o(hi_en_o),
        .lo_en_o(lo_en_o)
    );

endmodule

// File: rtl/hpd_checker.sv
module hpd_checker #(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       sync_val,
    input logic [6:0]       seg,
    input logic             hi_en,
    input logic             lo_en
);

    // R5
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        hi_en != lo_en);

    // R1
    reset_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lo_en && !hi_en && cnt == '0));

    // R2
    phase_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hi_en != $past(hi_en)) |-> (cnt[CNT_W-2:0] == '0));

    // R6
    glyph_lit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(seg) >= 2);

    // R7
    seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(sync_val) && $stable(hi_en)) |-> $stable(seg));

endmodule

bind hex_pair_display hpd_checker #(.CNT_W(CNT_W)) u_hpd_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt     (sel_cnt),
    .sync_val(sw_sync),
    .seg     (seg_o),
    .hi_en   (hi_en_o),
    .lo_en   (lo_en_o)
);

// File: tb/tb_hex_pair_display.sv
module tb_hex_pair_display;

    localparam int CW = 4;
    localparam int HALF = 1 << (CW - 1);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sw  = 8'h00;
    logic [6:0] seg;
    logic       hi_en, lo_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    hex_pair_display #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
        .clk    (clk),
        .rst    (rst),
        .sw_i   (sw),
        .seg_o  (seg),
        .hi_en_o(hi_en),
        .lo_en_o(lo_en)
    );

    always #4 clk = ~clk;

    // Reference: cycle count since reset and two-edge switch delay
    logic [CW-1:0] m_cnt = '0;
    logic [7:0]    m_d1 = '0, m_d2 = '0;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_d1 <= '0; m_d2 <= '0;
        end else begin
            m_cnt <= m_cnt + 1'b1; m_d1 <= sw; m_d2 <= m_d1;
        end
    end

    function automatic logic [6:0] glyph(input logic [3:0] v);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[v];
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Full compare at a negedge against the model
    task automatic check_all();
        logic hi;
        logic [3:0] nib;
        hi  = m_cnt[CW-1];
        nib = hi ? m_d2[7:4] : m_d2[3:0];
        chk(hi ? "R3 upper nibble glyph" : "R4 lower nibble glyph",
            {2'b00, seg}, {2'b00, glyph(nib)});
        chk("R2 R5 enables", {7'b0, hi_en, lo_en}, {7'b0, hi, ~hi});
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        sw = 8'hA7;
        repeat (3) step();
        // R1 reset state
        chk("R1 reset seg", {2'b0, seg}, 9'h03F);
        chk("R1 reset enables", {7'b0, hi_en, lo_en}, 9'h001);
        rst = 1'b0;
        step();
        chk("R1 first cycle low phase", {7'b0, hi_en, lo_en}, 9'h001);
        // R2 phase length: count cycles until hi_en rises, then falls
        begin
            int n = 1;
            while (!hi_en && n < 100) begin step(); n++; end
            chk("R2 low phase length", 9'(n), 9'(HALF));
            n = 0;
            while (hi_en && n < 100) begin step(); n++; end
            chk("R2 high phase length", 9'(n), 9'(HALF));
        end
        // R6 all glyphs on both digits
        for (int v = 0; v < 16; v++) begin
            sw = {4'(v), 4'(15 - v)};
            for (int k = 0; k < 2 * HALF; k++) begin
                step();
                check_all();
                if (k > 2 && hi_en)  chk("R6 R3 glyph table", {2'b0, seg}, {2'b0, glyph(4'(v))});
                if (k > 2 && lo_en)  chk("R6 R4 glyph table", {2'b0, seg}, {2'b0, glyph(4'(15 - v))});
            end
        end
        // R7 latency: wait for a low phase with room, change low nibble
        while (!(lo_en && m_cnt[CW-2:0] == 1)) step();
        sw = 8'h00; step(); step(); step();
        sw = 8'h0E;
        step();
        chk("R7 not yet after one edge", {2'b0, seg}, {2'b0, glyph(4'h0)});
        step();
        chk("R7 visible after two edges", {2'b0, seg}, {2'b0, glyph(4'hE)});
        // Random stimulus
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) sw = 8'($urandom);
            step();
            check_all();
        end
        // Reset mid-run returns to low phase
        rst = 1'b1; sw = 8'h5C; step();
        chk("R1 reset mid-run", {7'b0, hi_en, lo_en}, 9'h001);
        chk("R1 reset seg mid-run", {2'b0, seg}, 9'h03F);
        rst = 1'b0;
        for (int i = 0; i < 40; i++) begin step(); check_all(); end
        done = 1;
    end

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=complete");
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule